// File: doc/BRIEF.md
# Compressed-Branch Resolution Unit

This unit resolves the branch-class members of a 16-bit instruction encoding. The pipeline presents one 16-bit instruction together with the halfword that follows it, the address of the instruction, the four condition flags and the current link register. The unit works out whether a branch is taken, the new program counter, any new link value, and whether the pipeline must be flushed. It also reports encodings that are undefined and encodings that request a software trap. For a trap it builds the 32-bit trap word that the host needs. Fetching instructions is not part of this unit.

A long call is split over two consecutive halfwords. The first half loads the upper part of the offset into the link register. The second half adds the lower part and jumps. When the halfword after a first half is a matching second half, the unit resolves both halves in one step and reports that it consumed two halves. A second half that arrives on its own jumps relative to whatever the link register holds.

The control is a two-state machine. In ST_IDLE nothing is reported. A start strobe moves it to ST_SHOW (transition "accept"), and the registered result is visible there for one cycle. A further strobe while in ST_SHOW keeps it in ST_SHOW with the new result ("chain"). A cycle without a strobe returns it to ST_IDLE ("retire").

Top module: `cbu_branch_unit`

## Requirements
- R1: While reset is held, and until the first start strobe, res_valid, pc_we, link_we, flush, undef, trap and pair are 0, and pc_out, link_out and trap_word are 0.
- R2: A start strobe sampled at a clock edge makes res_valid 1 in the cycle after that edge, together with that instruction's result. Any cycle whose preceding edge saw no strobe has res_valid 0 and every other output 0.
- R3: When instr[15:12] = 4'b1101 and the condition code instr[11:8] is in 0..13, the branch is taken according to flags = {N,Z,C,V} (bit 3 down to bit 0). The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R4: A taken conditional branch gives pc_we=1, flush=1 and pc_out = pc + 4 + sign-extend(instr[7:0] << 1), where the offset's sign is instr[7].
- R5: A conditional branch that is not taken gives pc_we=0, pc_out=0 and flush=0, with res_valid=1.
- R6: Condition code 14 under instr[15:12]=4'b1101, and any instruction with instr[15:11]=29, gives undef=1. No PC or link write, flush or trap follows.
- R7: instr[15:11]=28 always jumps: pc_out = pc + 4 + sign-extend(instr[10:0] << 1), with the sign taken from instr[10]. pc_we and flush are 1.
- R8: instr[15:11]=30, when instr_next[15:11] is not 31, gives link_we=1 and link_out = pc + 4 + sign-extend(instr[10:0] << 12). There is no PC write, no flush, and pair=0.
- R9: instr[15:11]=30 followed by instr_next[15:11]=31 gives pair=1 and pc_out = (pc + 4 + sign-extend(instr[10:0] << 12)) + (instr_next[10:0] << 1). It also gives link_out = (pc + 4) | 1, with pc_we, link_we and flush all 1.
- R10: instr[15:11]=31 on its own gives pc_out = link_in + (instr[10:0] << 1) and link_out = (pc + 2) | 1, with pc_we, link_we and flush all 1.
- R11: Condition code 15 under instr[15:12]=4'b1101 gives trap=1, with no flush and no PC write. Let imm be instr[7:0]. trap_word is TRAP_BASE | (imm << 16) when imm = 8'h18, TRAP_BASE | BRK_CODE when imm = 8'hFE, and TRAP_BASE | imm otherwise. The defaults are TRAP_BASE = 32'hEF00_0000 and BRK_CODE = 32'h0000_00A5.
- R12: Any instruction with instr[15:11] below 26 is not a branch. It gives res_valid=1 with every other output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe: resolve the presented instruction |
| instr | input | 16 | Instruction halfword |
| instr_next | input | 16 | Halfword that follows instr |
| pc | input | 32 | Address of instr |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| link_in | input | 32 | Current link register |
| res_valid | output | 1 | Result present this cycle |
| pc_out | output | 32 | New program counter |
| pc_we | output | 1 | Program counter write enable |
| link_out | output | 32 | New link register value |
| link_we | output | 1 | Link register write enable |
| flush | output | 1 | Pipeline flush pulse |
| undef | output | 1 | Undefined encoding |
| trap | output | 1 | Software trap encoding |
| trap_word | output | 32 | Trap word built for the host |
| pair | output | 1 | Both halves of a long call consumed |

## Verification
The hardest situation to reach from the ports is the boundary between the fused and the unfused long call. The same first half must be resolved once with a matching second half in instr_next and once without it, and a second half must also be sent on its own against a chosen link_in. The stimulus builds these three cases explicitly, with offsets at both sign extremes and a PC close to the top of the address space so that the sums wrap. Every combination of the 16 condition codes and the 16 flag patterns is also sent back to back, with offsets that rotate through both signs.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    localparam int ADDR_W  = 32;
    localparam int INSN_W  = 16;
    localparam int SEL_W   = 5;
    localparam int CC_W    = 4;
    localparam int LOFF_W  = 11;
    localparam int SOFF_W  = 8;
    localparam int HI_SH   = 12;

    localparam logic [SEL_W-1:0] SEL_JUMP    = 5'd28;
    localparam logic [SEL_W-1:0] SEL_UNDEF   = 5'd29;
    localparam logic [SEL_W-1:0] SEL_LONG_HI = 5'd30;
    localparam logic [SEL_W-1:0] SEL_LONG_LO = 5'd31;
    localparam logic [3:0]       COND_GROUP  = 4'b1101;
    localparam logic [CC_W-1:0]  CC_UNDEF    = 4'hE;
    localparam logic [CC_W-1:0]  CC_TRAP     = 4'hF;

    typedef enum logic [2:0] {
        K_OTHER,
        K_COND,
        K_TRAP,
        K_UNDEF,
        K_JUMP,
        K_LONG_HI,
        K_LONG_LO
    } kind_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic              pc_we;
        logic [ADDR_W-1:0] pc_val;
        logic              link_we;
        logic [ADDR_W-1:0] link_val;
        logic              flush;
        logic              undef;
        logic              trap;
        logic [ADDR_W-1:0] trap_word;
        logic              pair;
    } result_t;

endpackage

// File: rtl/cbu_classify.sv
module cbu_classify
    import cbu_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output kind_t             kind
);

    logic [SEL_W-1:0] sel;
    logic [CC_W-1:0]  cc;

    assign sel = instr[INSN_W-1 -: SEL_W];
    assign cc  = instr[11:8];

    always_comb begin
        kind = K_OTHER;
        if (instr[15:12] == COND_GROUP) begin
            if (cc == CC_TRAP)       kind = K_TRAP;
            else if (cc == CC_UNDEF) kind = K_UNDEF;
            else                     kind = K_COND;
        end else begin
            unique case (sel)
                SEL_JUMP:    kind = K_JUMP;
                SEL_UNDEF:   kind = K_UNDEF;
                SEL_LONG_HI: kind = K_LONG_HI;
                SEL_LONG_LO: kind = K_LONG_LO;
                default:     kind = K_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
    import cbu_pkg::*;
(
    input  logic [CC_W-1:0] code,
    input  flags_t          fl,
    output logic            take
);

    logic nv_same;
    assign nv_same = (fl.n == fl.v);

    always_comb begin
        take = 1'b0;
        unique case (code)
            4'h0:    take = fl.z;
            4'h1:    take = !fl.z;
            4'h2:    take = fl.c;
            4'h3:    take = !fl.c;
            4'h4:    take = fl.n;
            4'h5:    take = !fl.n;
            4'h6:    take = fl.v;
            4'h7:    take = !fl.v;
            4'h8:    take = fl.c && !fl.z;
            4'h9:    take = !fl.c || fl.z;
            4'hA:    take = nv_same;
            4'hB:    take = !nv_same;
            4'hC:    take = !fl.z && nv_same;
            4'hD:    take = fl.z || !nv_same;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbu_target.sv
module cbu_target
    import cbu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TRAP_BASE = 32'hEF00_0000,
    parameter logic [ADDR_W-1:0] BRK_CODE  = 32'h0000_00A5
) (
    input  logic [INSN_W-1:0] instr,
    input  logic [INSN_W-1:0] instr_next,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] link_in,
    input  kind_t             kind,
    input  logic              take,
    output result_t           res
);

    localparam int STEP   = INSN_W / 8;
    localparam int HI_TOP = LOFF_W + HI_SH;

    logic [ADDR_W-1:0] pc_seq;
    logic [ADDR_W-1:0] pc_half;
    logic [ADDR_W-1:0] off_cond;
    logic [ADDR_W-1:0] off_jump;
    logic [ADDR_W-1:0] off_hi;
    logic [ADDR_W-1:0] off_lo_here;
    logic [ADDR_W-1:0] off_lo_next;
    logic [ADDR_W-1:0] link_hi;
    logic              fuse;
    logic [SOFF_W-1:0] imm;

    assign pc_half     = pc + ADDR_W'(STEP);
    assign pc_seq      = pc + ADDR_W'(2 * STEP);
    assign off_cond    = {{(ADDR_W-SOFF_W-1){instr[SOFF_W-1]}}, instr[SOFF_W-1:0], 1'b0};
    assign off_jump    = {{(ADDR_W-LOFF_W-1){instr[LOFF_W-1]}}, instr[LOFF_W-1:0], 1'b0};
    assign off_hi      = {{(ADDR_W-HI_TOP){instr[LOFF_W-1]}}, instr[LOFF_W-1:0], {HI_SH{1'b0}}};
    assign off_lo_here = {{(ADDR_W-LOFF_W-1){1'b0}}, instr[LOFF_W-1:0], 1'b0};
    assign off_lo_next = {{(ADDR_W-LOFF_W-1){1'b0}}, instr_next[LOFF_W-1:0], 1'b0};
    assign link_hi     = pc_seq + off_hi;
    assign fuse        = (instr_next[INSN_W-1 -: SEL_W] == SEL_LONG_LO);
    assign imm         = instr[SOFF_W-1:0];

    always_comb begin
        res = '0;
        unique case (kind)
            K_COND: begin
                if (take) begin
                    res.pc_we  = 1'b1;
                    res.pc_val = pc_seq + off_cond;
                    res.flush  = 1'b1;
                end
            end
            K_JUMP: begin
                res.pc_we  = 1'b1;
                res.pc_val = pc_seq + off_jump;
                res.flush  = 1'b1;
            end
            K_UNDEF: begin
                res.undef = 1'b1;
            end
            K_TRAP: begin
                res.trap = 1'b1;
                if (imm == 8'h18)
                    res.trap_word = TRAP_BASE | {8'h00, imm, 16'h0000};
                else if (imm == 8'hFE)
                    res.trap_word = TRAP_BASE | BRK_CODE;
                else
                    res.trap_word = TRAP_BASE | {24'h0, imm};
            end
            K_LONG_HI: begin
                res.link_we = 1'b1;
                if (fuse) begin
                    res.pc_we    = 1'b1;
                    res.pc_val   = link_hi + off_lo_next;
                    res.link_val = pc_seq | ADDR_W'(1);
                    res.flush    = 1'b1;
                    res.pair     = 1'b1;
                end else begin
                    res.link_val = link_hi;
                end
            end
            K_LONG_LO: begin
                res.pc_we    = 1'b1;
                res.pc_val   = link_in + off_lo_here;
                res.link_we  = 1'b1;
                res.link_val = pc_half | ADDR_W'(1);
                res.flush    = 1'b1;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/cbu_branch_unit.sv
module cbu_branch_unit
    import cbu_pkg::*;
#(
    parameter logic [31:0] TRAP_BASE = 32'hEF00_0000,
    parameter logic [31:0] BRK_CODE  = 32'h0000_00A5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] instr,
    input  logic [15:0] instr_next,
    input  logic [31:0] pc,
    input  logic [3:0]  flags,
    input  logic [31:0] link_in,
    output logic        res_valid,
    output logic [31:0] pc_out,
    output logic        pc_we,
    output logic [31:0] link_out,
    output logic        link_we,
    output logic        flush,
    output logic        undef,
    output logic        trap,
    output logic [31:0] trap_word,
    output logic        pair
);

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_SHOW
    } state_t;

    state_t  state_q, state_d;
    kind_t   kind;
    logic    take;
    flags_t  fl;
    result_t res_d, res_q;

    assign fl = flags_t'(flags);

    cbu_classify u_classify (
        .instr (instr),
        .kind  (kind)
    );

    cbu_cond u_cond (
        .code (instr[11:8]),
        .fl   (fl),
        .take (take)
    );

    cbu_target #(
        .TRAP_BASE (TRAP_BASE),
        .BRK_CODE  (BRK_CODE)
    ) u_target (
        .instr      (instr),
        .instr_next (instr_next),
        .pc         (pc),
        .link_in    (link_in),
        .kind       (kind),
        .take       (take),
        .res        (res_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SHOW;
            ST_SHOW: state_d = start ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     res_q <= '0;
        else if (start) res_q <= res_d;
        else            res_q <= '0;
    end

    assign res_valid = (state_q == ST_SHOW);
    assign pc_out    = res_q.pc_val;
    assign pc_we     = res_q.pc_we;
    assign link_out  = res_q.link_val;
    assign link_we   = res_q.link_we;
    assign flush     = res_q.flush;
    assign undef     = res_q.undef;
    assign trap      = res_q.trap;
    assign trap_word = res_q.trap_word;
    assign pair      = res_q.pair;

    p_valid_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> res_valid);
    p_quiet_without_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !res_valid && !pc_we && !link_we && !flush && !trap && !undef);
    p_write_flushes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> flush);
    p_undef_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> !pc_we && !link_we && !trap && !flush);
    p_pair_links_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pair |-> link_we && flush && link_out[0]);
    p_trap_no_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !flush && !pc_we);
    p_effects_need_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || link_we || undef || trap) |-> res_valid);

endmodule

// File: tb/test_cbu_branch_unit.sv
`timescale 1ns/100ps
module test_cbu_branch_unit;

    localparam logic [31:0] T_BASE = 32'hEF00_0000;
    localparam logic [31:0] T_BRK  = 32'h0000_00A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] instr_next = '0;
    logic [31:0] pc = '0;
    logic [3:0]  flags = '0;
    logic [31:0] link_in = '0;
    logic        res_valid, pc_we, link_we, flush, undef, trap, pair;
    logic [31:0] pc_out, link_out, trap_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [101:0] q_exp[$];
    string        q_tag[$];

    always #2.5 clk = ~clk;

    cbu_branch_unit i_cbu_branch_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .instr_next(instr_next), .pc(pc), .flags(flags), .link_in(link_in),
        .res_valid(res_valid), .pc_out(pc_out), .pc_we(pc_we),
        .link_out(link_out), .link_we(link_we), .flush(flush),
        .undef(undef), .trap(trap), .trap_word(trap_word), .pair(pair)
    );

    function automatic logic [101:0] observed();
        return {pc_we, pc_out, link_we, link_out, flush, undef, trap, trap_word, pair};
    endfunction

    function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    function automatic logic [101:0] model(input logic [15:0] i, input logic [15:0] nx,
                                           input logic [31:0] p, input logic [3:0] f,
                                           input logic [31:0] lk);
        logic        e_pcwe = 0, e_lkwe = 0, e_fl = 0, e_ud = 0, e_tr = 0, e_pr = 0;
        logic [31:0] e_pc = 0, e_lk = 0, e_tw = 0;
        int          s = i[15:11];
        logic [31:0] hi;
        hi = p + 32'd4 + ({{21{i[10]}}, i[10:0]} << 12);
        if (i[15:12] == 4'hD) begin
            if (i[11:8] == 4'hF) begin
                e_tr = 1;
                if (i[7:0] == 8'h18)      e_tw = T_BASE + (32'h18 << 16);
                else if (i[7:0] == 8'hFE) e_tw = T_BASE | T_BRK;
                else                      e_tw = T_BASE + {24'h0, i[7:0]};
            end else if (i[11:8] == 4'hE) begin
                e_ud = 1;
            end else if (cond_ok(i[11:8], f)) begin
                e_pcwe = 1; e_fl = 1;
                e_pc = p + 32'd4 + {{23{i[7]}}, i[7:0], 1'b0};
            end
        end else if (s == 28) begin
            e_pcwe = 1; e_fl = 1;
            e_pc = p + 32'd4 + {{20{i[10]}}, i[10:0], 1'b0};
        end else if (s == 29) begin
            e_ud = 1;
        end else if (s == 30) begin
            e_lkwe = 1;
            if (nx[15:11] == 5'd31) begin
                e_pr = 1; e_pcwe = 1; e_fl = 1;
                e_pc = hi + {20'h0, nx[10:0], 1'b0};
                e_lk = (p + 32'd4) | 32'd1;
            end else begin
                e_lk = hi;
            end
        end else if (s == 31) begin
            e_pcwe = 1; e_lkwe = 1; e_fl = 1;
            e_pc = lk + {20'h0, i[10:0], 1'b0};
            e_lk = (p + 32'd2) | 32'd1;
        end
        return {e_pcwe, e_pc, e_lkwe, e_lk, e_fl, e_ud, e_tr, e_tw, e_pr};
    endfunction

    task automatic send(input logic [15:0] i, input logic [15:0] nx, input logic [31:0] p,
                        input logic [3:0] f, input logic [31:0] lk, input string tag);
        @(negedge clk);
        instr = i; instr_next = nx; pc = p; flags = f; link_in = lk; start = 1'b1;
        q_exp.push_back(model(i, nx, p, f, lk));
        q_tag.push_back(tag);
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [101:0] act,
                         input logic [101:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                if (q_exp.size() == 0) begin
                    check(0, "R2 unexpected result", observed(), '0);
                end else begin
                    logic [101:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check(observed() === e, t, observed(), e);
                end
            end else if (observed() !== '0) begin
                check(0, "R2 outputs while idle", observed(), '0);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({res_valid, observed()} === '0, "R1 reset state", observed(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check({res_valid, observed()} === '0, "R1 after release", observed(), '0);

        // R3: every condition code against every flag pattern, offsets rotating sign
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                logic [7:0] off;
                off = 8'((cc * 16 + f) * 37);
                send({4'hD, 4'(cc), off}, 16'h0000, 32'h0000_1000 + 32'(cc * 64 + f * 2),
                     4'(f), 32'h0, cc == 15 ? "R11" : (cc == 14 ? "R6" : "R3"));
            end
        end
        quiet(2);

        // R4 / R5: offset sign corners on taken and untaken branches
        send(16'hD07F, 16'h0, 32'h0000_2000, 4'b0100, 32'h0, "R4 max positive");
        send(16'hD080, 16'h0, 32'h0000_2000, 4'b0100, 32'h0, "R4 max negative");
        send(16'hD0FF, 16'h0, 32'h0000_0000, 4'b0100, 32'h0, "R4 minus one wrap");
        send(16'hD000, 16'h0, 32'hFFFF_FFFC, 4'b0100, 32'h0, "R4 top wrap");
        send(16'hD180, 16'h0, 32'h0000_2000, 4'b0100, 32'h0, "R5 untaken");
        send(16'hDC10, 16'h0, 32'h0000_2000, 4'b1100, 32'h0, "R5 untaken gt");
        quiet(1);

        // R7: unconditional jump sign corners
        send({5'd28, 11'h000}, 16'h0, 32'h0000_3000, 4'h0, 32'h0, "R7 zero");
        send({5'd28, 11'h3FF}, 16'h0, 32'h0000_3000, 4'h0, 32'h0, "R7 max positive");
        send({5'd28, 11'h400}, 16'h0, 32'h0000_3000, 4'h0, 32'h0, "R7 max negative");
        send({5'd28, 11'h7FF}, 16'h0, 32'hFFFF_FFF0, 4'h0, 32'h0, "R7 wrap");

        // R6: undefined selector
        send({5'd29, 11'h123}, 16'h0, 32'h0000_4000, 4'hF, 32'h1234_5678, "R6 selector");
        send(16'hDE00, 16'h0, 32'h0000_4000, 4'hF, 32'h0, "R6 cond 14");

        // R8: first half without its partner
        send({5'd30, 11'h400}, {5'd28, 11'h001}, 32'h0000_5000, 4'h0, 32'h0, "R8 negative");
        send({5'd30, 11'h3FF}, 16'hD001, 32'h0000_5000, 4'h0, 32'h0, "R8 positive");
        send({5'd30, 11'h001}, {5'd30, 11'h7FF}, 32'hFFFF_FFFE, 4'h0, 32'h0, "R8 wrap");

        // R9: fused pair
        send({5'd30, 11'h001}, {5'd31, 11'h7FF}, 32'h0000_6000, 4'h0, 32'h0, "R9 pair");
        send({5'd30, 11'h7FF}, {5'd31, 11'h000}, 32'h0000_6000, 4'h0, 32'h0, "R9 back");
        send({5'd30, 11'h400}, {5'd31, 11'h555}, 32'hFFFF_FFFC, 4'h0, 32'h0, "R9 wrap");

        // R10: lone second half
        send({5'd31, 11'h123}, 16'h0, 32'h0000_7000, 4'h0, 32'h0000_8000, "R10 lone");
        send({5'd31, 11'h7FF}, 16'h0, 32'hFFFF_FFFE, 4'h0, 32'hFFFF_F000, "R10 wrap");

        // R11: trap word forms
        send(16'hDF18, 16'h0, 32'h0, 4'h0, 32'h0, "R11 imm 0x18");
        send(16'hDFFE, 16'h0, 32'h0, 4'h0, 32'h0, "R11 brk");
        send(16'hDF05, 16'h0, 32'h0, 4'h0, 32'h0, "R11 plain");
        send(16'hDF00, 16'h0, 32'h0, 4'h0, 32'h0, "R11 zero");

        // R12: non-branch selectors
        send(16'h0000, {5'd31, 11'h1}, 32'h0000_9000, 4'hF, 32'h0, "R12 zero");
        send(16'h4567, 16'h0, 32'h0000_9000, 4'hF, 32'h0, "R12 mid");
        send(16'hC8FF, {5'd31, 11'h1}, 32'h0000_9000, 4'hF, 32'h0, "R12 sel 25");
        quiet(4);

        check(q_exp.size() == 0, "R2 results outstanding", 102'(q_exp.size()), '0);
        done = 1;
        summary();
        $finish;
    end

endmodule